// File: doc/BRIEF.md
# MDIO Management Master

This block drives a two-wire station management bus toward an Ethernet PHY. Each accepted request becomes exactly one register transaction, either a read or a write. The block produces the management clock by dividing the system clock. It drives the data wire through a split output, output-enable and input triple, so an I/O pad outside the block can form the bidirectional pin.

A host pulses `start` with the direction, a PHY number, a register number and, for a write, the value to store. `busy` stays high while the frame is on the wire. `done` marks the end of the frame. For a read, the fetched value then appears on `rdData`.

On a read, the controller listens for the PHY to pull the wire low in the turnaround slot. If the PHY does not, the read is abandoned and a flag is raised. The controller then sends a long run of clocks with the wire released, so that a confused PHY can fall back to idle.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 MDC cycles in which `mdioOe` is 1 and `mdioOut` is 1 at each MDC rising edge.
- R2: Rising edges 32..45 carry, with `mdioOe` 1: start pattern 0,1; then opcode 1,0 for a read or 0,1 for a write; then the 5-bit PHY number MSB first; then the 5-bit register number MSB first.
- R3: `mdioOut` and `mdioOe` change only while `mdc` is low. Each low half and each high half of `mdc` lasts HALF_DIV system clocks.
- R4: A write drives turnaround 1,0 at edges 46..47 and the 16 data bits MSB first at edges 48..63. Edge 64 follows with `mdioOe` 0, for 65 rising edges in all. `rdData` does not change.
- R5: From edge 46 onward a read keeps `mdioOe` at 0. The input at edge 46 must be 0. Inputs at edges 47..62 form `rdData` MSB first. Two more clocks follow, for 65 rising edges in all, and `rdData` is valid when `done` pulses.
- R6: If the input at edge 46 of a read is 1, the controller issues 32 further released clocks (79 rising edges in all). It then finishes with `taError` 1 and leaves `rdData` at its previous value.
- R7: `taError` keeps its value after `done` until the next accepted `start`, which clears it.
- R8: `done` is high for exactly one clock, on the clock edge of the final MDC falling edge. `busy` is 0 in that cycle. That edge comes 2*HALF_DIV*(rising-edge count) clocks after the edge that accepted `start`.
- R9: `start` is ignored while `busy` is 1. The running frame keeps the fields captured at acceptance, and no second frame follows.
- R10: After reset and between frames, `mdc` is 0, `mdioOe` is 0, `busy` is 0 and `done` is 0. Reset also clears `taError` and `rdData` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, taken only when idle |
| rdNotWr | input | 1 | 1 selects a read, 0 a write |
| phyAddr | input | 5 | Target PHY number |
| regAddr | input | 5 | Target register number |
| wrData | input | 16 | Value for a write |
| rdData | output | 16 | Result of the last successful read |
| done | output | 1 | One-clock end-of-transaction pulse |
| busy | output | 1 | Frame in progress |
| taError | output | 1 | Last read saw no turnaround response |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data value driven toward the pad |
| mdioOe | output | 1 | Drive enable for the data pad |
| mdioIn | input | 1 | Data value sampled from the pad |

## Verification
An off-by-one in the bit counters or the state order would surface at the next MDC rising edge. It would show as a wrong bit, or a wrong drive-enable value, in the captured frame. It would also show in the total number of rising edges and in the cycle on which `done` appears, all checked when the frame completes. A slip in the half-period counter shows within one MDC half, through the measured edge spacing. A mishandled turnaround shows as a 65-edge frame where 79 were due, or as an `rdData` that changed when it should not.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;
  // start(2) + opcode(2) + phy number + register number
  localparam int unsigned HDR_BITS = 4 + 2 * ADDR_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_WTA,
    ST_WDAT,
    ST_RTA,
    ST_RDAT,
    ST_RECOV,
    ST_TAIL
  } mdioState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture request fields into the frame shifter
    logic advance;  // present the next frame bit (MDC falling)
    logic capture;  // shift the synchronised input into the read shifter
    logic commit;   // move the read shifter to the result port
  } dpCtl_t;

endpackage

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            dpCtl,
  input  logic              rdNotWr,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mdioOe,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioSync,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned FRAME_W = PRE_LEN + HDR_BITS + 2 + DATA_W;

  logic [FRAME_W-1:0]     txShift;
  logic [DATA_W-1:0]      rxShift;
  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
    end else if (dpCtl.load) begin
      txShift <= {{PRE_LEN{1'b1}}, 2'b01, (rdNotWr ? 2'b10 : 2'b01),
                  phyAddr, regAddr, 2'b10, wrData};
    end else if (dpCtl.advance) begin
      txShift <= {txShift[FRAME_W-2:0], 1'b0};
    end
  end

  assign mdioOut = txShift[FRAME_W-1] & mdioOe;

  // input synchroniser, idle level of the bus is high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '1;
        else     syncQ <= mdioIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '1;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], mdioIn};
      end
    end
  endgenerate

  assign mdioSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift <= '0;
      rdData  <= '0;
    end else begin
      if (dpCtl.capture) rxShift <= {rxShift[DATA_W-2:0], mdioSync};
      if (dpCtl.commit)  rdData  <= rxShift;
    end
  end

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_DIV  = 100,
  parameter int unsigned PRE_LEN   = 32,
  parameter int unsigned RECOV_LEN = 32
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   rdNotWr,
  input  logic   mdioSync,
  output logic   mdc,
  output logic   mdioOe,
  output logic   busy,
  output logic   done,
  output logic   taError,
  output dpCtl_t dpCtl
);

  localparam int unsigned HC_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned MAX_LEN = (PRE_LEN > RECOV_LEN)
                                    ? ((PRE_LEN > DATA_W) ? PRE_LEN : DATA_W)
                                    : ((RECOV_LEN > DATA_W) ? RECOV_LEN : DATA_W);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  mdioState_t       state, nextState;
  logic [HC_W-1:0]  halfCnt;
  logic [CNT_W-1:0] bitCnt, lastIdx;
  logic             mdcQ, isRead, doneQ, errQ;
  logic             halfEnd, bitEnd, lastBit, accept;

  assign accept  = (state == ST_IDLE) && start;
  assign halfEnd = (halfCnt == HC_W'(HALF_DIV - 1));
  assign bitEnd  = halfEnd && mdcQ;
  assign lastBit = (bitCnt == lastIdx);

  always_comb begin
    unique case (state)
      ST_PRE:   lastIdx = CNT_W'(PRE_LEN - 1);
      ST_HDR:   lastIdx = CNT_W'(HDR_BITS - 1);
      ST_WTA:   lastIdx = CNT_W'(1);
      ST_WDAT:  lastIdx = CNT_W'(DATA_W - 1);
      ST_RTA:   lastIdx = '0;
      ST_RDAT:  lastIdx = CNT_W'(DATA_W - 1);
      ST_RECOV: lastIdx = CNT_W'(RECOV_LEN - 1);
      ST_TAIL:  lastIdx = isRead ? CNT_W'(1) : '0;
      default:  lastIdx = '0;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_PRE:   nextState = ST_HDR;
      ST_HDR:   nextState = isRead ? ST_RTA : ST_WTA;
      ST_WTA:   nextState = ST_WDAT;
      ST_WDAT:  nextState = ST_TAIL;
      ST_RTA:   nextState = mdioSync ? ST_RECOV : ST_RDAT;
      ST_RDAT:  nextState = ST_TAIL;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
      mdcQ    <= 1'b0;
      isRead  <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (state == ST_IDLE) begin
        halfCnt <= '0;
        mdcQ    <= 1'b0;
        if (start) begin
          state  <= ST_PRE;
          bitCnt <= '0;
          isRead <= rdNotWr;
          errQ   <= 1'b0;
        end
      end else begin
        if (halfEnd) begin
          halfCnt <= '0;
          mdcQ    <= ~mdcQ;
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
        if (bitEnd) begin
          if (lastBit) begin
            bitCnt <= '0;
            state  <= nextState;
            if (state == ST_TAIL || state == ST_RECOV) begin
              doneQ <= 1'b1;
              errQ  <= (state == ST_RECOV);
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
    end
  end

  assign dpCtl.load    = accept;
  assign dpCtl.advance = bitEnd;
  assign dpCtl.capture = bitEnd && (state == ST_RDAT);
  assign dpCtl.commit  = bitEnd && lastBit && (state == ST_TAIL) && isRead;

  assign mdioOe  = (state == ST_PRE) || (state == ST_HDR) ||
                   (state == ST_WTA) || (state == ST_WDAT);
  assign mdc     = mdcQ;
  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;
  assign taError = errQ;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_DIV  = 100,
  parameter int unsigned PRE_LEN   = 32,
  parameter int unsigned RECOV_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        rdNotWr,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        done,
  output logic        busy,
  output logic        taError,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  dpCtl_t dpCtl;
  logic   mdioSync;

  mdio_ctrl #(
    .HALF_DIV (HALF_DIV),
    .PRE_LEN  (PRE_LEN),
    .RECOV_LEN(RECOV_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .rdNotWr (rdNotWr),
    .mdioSync(mdioSync),
    .mdc     (mdc),
    .mdioOe  (mdioOe),
    .busy    (busy),
    .done    (done),
    .taError (taError),
    .dpCtl   (dpCtl)
  );

  mdio_dp #(
    .PRE_LEN    (PRE_LEN),
    .SYNC_STAGES(2)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .dpCtl   (dpCtl),
    .rdNotWr (rdNotWr),
    .phyAddr (phyAddr),
    .regAddr (regAddr),
    .wrData  (wrData),
    .mdioOe  (mdioOe),
    .mdioIn  (mdioIn),
    .mdioOut (mdioOut),
    .mdioSync(mdioSync),
    .rdData  (rdData)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned HALF_DIV = 100
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic taError,
  input logic mdc,
  input logic mdioOe,
  input logic mdioOut
);

  logic        mdcQ;
  logic [31:0] holdCnt;

  // counts the clocks mdc has held its level during a frame
  always_ff @(posedge clk) begin
    if (rst) begin
      mdcQ    <= 1'b0;
      holdCnt <= '0;
    end else begin
      mdcQ <= mdc;
      if (!busy)             holdCnt <= '0;
      else if (mdc != mdcQ)  holdCnt <= 32'd1;
      else                   holdCnt <= holdCnt + 32'd1;
    end
  end

  a_r3_out_low_mdc: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdioOut) |-> !mdc);

  a_r3_oe_low_mdc: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdioOe) |-> !mdc);

  a_r3_half_period: assert property (@(posedge clk) disable iff (rst)
    ((mdc != mdcQ) && $past(busy)) |-> (holdCnt == HALF_DIV));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdioOe));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r7_err_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(taError) |-> (done || $past(start && !busy)));

  a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .taError(taError),
  .mdc    (mdc),
  .mdioOe (mdioOe),
  .mdioOut(mdioOut)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HD         = 3;
  localparam int TA_EDGE    = 46;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rdNotWr = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        done, busy, taError, mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int failures = 0;
  logic [15:0] expRd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.HALF_DIV(HD)) u_mdio_master (
    .clk(clk), .rst(rst), .start(start), .rdNotWr(rdNotWr),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .done(done), .busy(busy), .taError(taError),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // ---------------- PHY side model ----------------
  logic        capOe  [0:127];
  logic        capVal [0:127];
  int          riseCnt = 0;
  int          periodErr = 0;
  time         lastRise = 0;
  logic        phyRead = 1'b0;
  logic        phyTa = 1'b0;
  logic [15:0] phyWord = '0;

  function automatic logic phyBit(input int k);
    if (!phyRead) return 1'b1;
    if (k == TA_EDGE) return phyTa;
    if (k > TA_EDGE && k <= TA_EDGE + 16) return phyWord[TA_EDGE + 16 - k];
    return 1'b1;
  endfunction

  always @(posedge mdc) begin
    if (riseCnt < 128) begin
      capOe[riseCnt]  = mdioOe;
      capVal[riseCnt] = mdioOut;
    end
    if (riseCnt > 0 && ($time - lastRise) != 2 * HD * CLK_PERIOD) periodErr++;
    lastRise = $time;
    riseCnt++;
  end

  always @(negedge mdc) begin
    if (riseCnt > 0 && ($time - lastRise) != HD * CLK_PERIOD) periodErr++;
    mdioIn <= phyBit(riseCnt);
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input bit rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
  endfunction

  task automatic runTxn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input bit ta, input logic [15:0] word,
                        input int injAt);
    logic [63:0] fr;
    int lat;
    int bad;
    int expRises;
    bit prevErr;
    prevErr = taError;
    fr = expFrame(rd, pa, ra, wd);
    expRises = (rd && ta) ? 79 : 65;
    @(negedge clk);
    riseCnt = 0; periodErr = 0;
    phyRead = rd; phyTa = ta; phyWord = word;
    rdNotWr = rd; phyAddr = pa; regAddr = ra; wrData = wd; start = 1'b1;
    lat = -1;
    for (int k = 1; k <= 6000; k++) begin
      @(negedge clk);
      if (k == injAt) begin
        start = 1'b1; rdNotWr = ~rd; phyAddr = ~pa; regAddr = ~ra; wrData = ~wd;
      end else begin
        start = 1'b0;
      end
      if (k == 2) begin
        chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
        if (prevErr) chk(taError == 1'b0, "R7", "taError cleared by start", taError, 0);
      end
      if (done) begin lat = k - 1; break; end
    end
    start = 1'b0;
    if (lat < 0) begin
      chk(1'b0, "R8", "watchdog no done", 0, 1);
      return;
    end
    chk(lat == 2 * HD * expRises, "R8", "done latency", lat, 2 * HD * expRises);
    chk(busy == 1'b0, "R8", "busy low with done", busy, 0);
    chk(!mdc && !mdioOe, "R10", "idle lines at done", {mdc, mdioOe}, 0);
    chk(taError == (rd && ta), "R6", "taError", taError, rd && ta);
    if (rd && !ta) expRd = word;
    chk(rdData == expRd, rd ? (ta ? "R6" : "R5") : "R4", "rdData", rdData, expRd);
    chk(riseCnt == expRises, rd ? (ta ? "R6" : "R5") : "R4", "rise count", riseCnt, expRises);
    chk(periodErr == 0, "R3", "mdc half period errors", periodErr, 0);

    bad = 0;
    for (int i = 0; i < 32; i++) if (!(capOe[i] && capVal[i])) bad++;
    chk(bad == 0, "R1", "preamble bad bits", bad, 0);
    bad = 0;
    for (int i = 32; i < TA_EDGE; i++) if (!(capOe[i] && capVal[i] == fr[63 - i])) bad++;
    chk(bad == 0, "R2", "header bad bits", bad, 0);
    bad = 0;
    if (!rd) begin
      for (int i = TA_EDGE; i < 64; i++) if (!(capOe[i] && capVal[i] == fr[63 - i])) bad++;
      if (capOe[64]) bad++;
      chk(bad == 0, "R4", "write tail bad bits", bad, 0);
    end else begin
      for (int i = TA_EDGE; i < expRises && i < 128; i++) if (capOe[i]) bad++;
      chk(bad == 0, "R5", "read released bad bits", bad, 0);
    end

    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
    if (injAt > 0) begin
      repeat (10) @(negedge clk);
      chk(busy == 1'b0 && riseCnt == expRises, "R9", "no frame from busy start",
          riseCnt, expRises);
    end
    if (rd && ta) begin
      repeat (20) @(negedge clk);
      chk(taError == 1'b1, "R7", "taError held", taError, 1);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mdc && !mdioOe && !busy && !done, "R10", "reset lines",
        {mdc, mdioOe, busy, done}, 0);
    chk(taError == 1'b0 && rdData == 16'h0, "R10", "reset flags", {taError, rdData}, 0);

    // directed corners
    runTxn(1'b0, 5'h1F, 5'h00, 16'hFFFF, 1'b0, 16'h0, 0);
    runTxn(1'b0, 5'h00, 5'h1F, 16'h0000, 1'b0, 16'h0, 0);
    runTxn(1'b1, 5'h15, 5'h0A, 16'h0, 1'b0, 16'hA5C3, 0);
    runTxn(1'b1, 5'h03, 5'h11, 16'h0, 1'b1, 16'h1234, 0);   // missing turnaround
    runTxn(1'b1, 5'h0C, 5'h02, 16'h0, 1'b0, 16'h8001, 0);   // error clears
    runTxn(1'b0, 5'h07, 5'h19, 16'h3C96, 1'b0, 16'h0, 120); // start while busy
    runTxn(1'b1, 5'h1E, 5'h05, 16'h0, 1'b0, 16'h7FFE, 200);

    // random mix
    for (int n = 0; n < 12; n++) begin
      bit rd;
      bit ta;
      int inj;
      rd  = 1'($urandom % 2);
      ta  = rd && (($urandom % 4) == 0);
      inj = (($urandom % 3) == 0) ? 50 + int'($urandom % 200) : 0;
      runTxn(rd, 5'($urandom), 5'($urandom), 16'($urandom), ta, 16'($urandom), inj);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule